// File: doc/BRIEF.md
# Split-Pin Serial Register Slave

This block is a two-wire serial slave. Through it an external host reads and writes a bank of 128 eight-bit control registers. The host drives a bit clock and a single input data line. The slave answers on a separate output pin. That pin carries an active-high acknowledge, and during reads it also carries each data bit inverted. A fast system clock samples both bus lines through a synchroniser. Start and stop conditions are found from edges of the data line while the bit clock is high.

A write transfer has three parts: the write device address, a register pointer byte, and any number of data bytes. Each data byte is stored at the pointer, and the pointer then steps forward. A read transfer first sets the pointer with a write transfer. The host then issues a stop, a new start and the read device address, and clocks out bytes from the pointer onward. The pointer is seven bits wide and wraps from 7Fh to 00h. Internal logic reads any register at any time through a separate parallel read port.

Top module: `ctl_serial_slave`

## Requirements
- R1: After the active-low reset `rst_n`, `ack_out` is low and every register reads 00h on the parallel port.
- R2: A falling `bus_dat` while `bus_clk` is high starts a transfer, including one that restarts a transfer in progress. A rising `bus_dat` while `bus_clk` is high is a stop. After a stop, bytes clocked before the next start change nothing and are not acknowledged.
- R3: After a start, the first byte is the device address, sent MSB first over clock cycles 1 to 8. For 24h (write) and for 25h (read), `ack_out` is high during the ninth cycle, the acknowledge slot.
- R4: Any other address byte gets no acknowledge, with `ack_out` low. The following bytes are ignored until the next start, and no register changes.
- R5: In a write transfer, the second byte loads the pointer and is acknowledged. Each later byte is written to the register at the pointer and is acknowledged, and the pointer then increments.
- R6: The pointer increments modulo 128, so the register that follows 7Fh is 00h. This applies to writes and to reads.
- R7: In a read transfer, each byte is taken from the register at the pointer left by the last write transfer. It is driven on `ack_out` inverted and MSB first, one bit per clock cycle, and the pointer increments after each byte.
- R8: During the acknowledge slot of a read byte, `ack_out` is low, leaving the line free for the host's own acknowledge. A stop drives `ack_out` low.
- R9: `ack_out` changes only after a falling `bus_clk` edge, a start or a stop, so it is stable while `bus_clk` is high.
- R10: The parallel port returns on `rd_data` the current contents of the register addressed by `rd_addr`, with no clock delay.
- R11: Only the low seven bits of the pointer byte are used. Bit 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | Serial bit clock from the host |
| bus_dat | input | 1 | Serial data input from the host |
| ack_out | output | 1 | Acknowledge (active high) and inverted read data |
| rd_addr | input | 7 | Parallel read port register index |
| rd_data | output | 8 | Parallel read port register value |

## Verification
The bench targets pointer wrap-around at 7Fh in both directions. A design that saturates or carries into an eighth bit would corrupt register 00h, or read back the wrong byte. A wrong device address is followed by more bytes, to catch a slave that stays awake after a mismatch and writes them. A restart in the middle of a transfer must re-arm address decoding, and a pointer byte with bit 7 set must still select registers 00h to 7Fh. Read bytes are compared bit for bit after inversion, and the acknowledge slot must show a released line. A design that leaves the inversion out, or holds the last data bit into the slot, fails these checks.

// File: rtl/ssl_pkg.sv
package ssl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ADDR  = 3'd1,
      ST_PTR   = 3'd2,
      ST_WDATA = 3'd3,
      ST_RDATA = 3'd4,
      ST_SKIP  = 3'd5
   } ssl_state_e;

   // bus events seen on the synchronised lines, one system clock wide
   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic dat;
   } ssl_evt_t;

endpackage

// File: rtl/ssl_sync.sv
module ssl_sync #(
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_clk,
   input  logic              bus_dat,
   output ssl_pkg::ssl_evt_t ev
);

   logic [STAGES-1:0] c_sh;
   logic [STAGES-1:0] d_sh;
   logic              c_q;
   logic              d_q;
   logic              c_s;
   logic              d_s;

   // idle bus is high on both lines, so the chains reset to ones
   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               c_sh <= '1;
               d_sh <= '1;
            end else begin
               c_sh <= bus_clk;
               d_sh <= bus_dat;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               c_sh <= '1;
               d_sh <= '1;
            end else begin
               c_sh <= {c_sh[STAGES-2:0], bus_clk};
               d_sh <= {d_sh[STAGES-2:0], bus_dat};
            end
         end
      end
   endgenerate

   assign c_s = c_sh[STAGES-1];
   assign d_s = d_sh[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_q <= 1'b1;
         d_q <= 1'b1;
      end else begin
         c_q <= c_s;
         d_q <= d_s;
      end
   end

   assign ev.start = c_s & c_q & d_q & ~d_s;
   assign ev.stop  = c_s & c_q & ~d_q & d_s;
   assign ev.rise  = c_s & ~c_q;
   assign ev.fall  = ~c_s & c_q;
   assign ev.dat   = d_s;

endmodule

// File: rtl/ssl_regfile.sv
module ssl_regfile #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [ADDR_W-1:0] raddr_b,
   output logic [DATA_W-1:0] rdata_b
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      for (genvar r = 0; r < DEPTH; r++) begin : g_row
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[r] <= '0;
            else if (we && (waddr == ADDR_W'(r)))
               mem[r] <= wdata;
         end
      end
   endgenerate

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];

   // R5: a write strobe leaves its byte in the addressed row
   a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/ssl_proto.sv
module ssl_proto #(
   parameter int         ADDR_W = 7,
   parameter int         DATA_W = 8,
   parameter logic [6:0] DEV_ID = 7'h12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ssl_pkg::ssl_evt_t ev,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] ptr,
   output logic              we,
   output logic [DATA_W-1:0] wdata,
   output logic              ack
);

   import ssl_pkg::*;

   localparam int            CNT_W   = 4;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W + 1);
   localparam logic [7:0]    ADR_WR  = {DEV_ID, 1'b0};
   localparam logic [7:0]    ADR_RD  = {DEV_ID, 1'b1};

   ssl_state_e        state;
   logic [CNT_W-1:0]  bitcnt;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] rbuf;
   logic              quiet;
   logic              byte_end;

   assign quiet    = (state == ST_IDLE) || (state == ST_SKIP);
   assign byte_end = ev.fall && !ev.start && !ev.stop && !quiet && (bitcnt == LAST_BIT);
   assign we       = byte_end && (state == ST_WDATA);
   assign wdata    = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         bitcnt <= '0;
         shreg  <= '0;
         rbuf   <= '0;
         ptr    <= '0;
         ack    <= 1'b0;
      end else if (ev.start) begin
         state  <= ST_ADDR;
         bitcnt <= '0;
         ack    <= 1'b0;
      end else if (ev.stop) begin
         state  <= ST_IDLE;
         bitcnt <= '0;
         ack    <= 1'b0;
      end else if (quiet) begin
         bitcnt <= '0;
      end else if (ev.rise) begin
         if (bitcnt < ACK_SLOT) bitcnt <= bitcnt + 1'b1;
         if (bitcnt < LAST_BIT) shreg <= {shreg[DATA_W-2:0], ev.dat};
      end else if (ev.fall) begin
         if (bitcnt == LAST_BIT) begin
            unique case (state)
               ST_ADDR: begin
                  if (shreg == ADR_WR) begin
                     state <= ST_PTR;
                     ack   <= 1'b1;
                  end else if (shreg == ADR_RD) begin
                     state <= ST_RDATA;
                     ack   <= 1'b1;
                  end else begin
                     state <= ST_SKIP;
                     ack   <= 1'b0;
                  end
               end
               ST_PTR: begin
                  ptr   <= shreg[ADDR_W-1:0];
                  state <= ST_WDATA;
                  ack   <= 1'b1;
               end
               ST_WDATA: begin
                  ptr <= ptr + 1'b1;
                  ack <= 1'b1;
               end
               ST_RDATA: begin
                  ptr <= ptr + 1'b1;
                  ack <= 1'b0;
               end
               default: ack <= 1'b0;
            endcase
         end else if (bitcnt == ACK_SLOT) begin
            bitcnt <= '0;
            if (state == ST_RDATA) begin
               rbuf <= {rdata[DATA_W-2:0], 1'b0};
               ack  <= ~rdata[DATA_W-1];
            end else begin
               ack  <= 1'b0;
            end
         end else if ((state == ST_RDATA) && (bitcnt != '0)) begin
            ack  <= ~rbuf[DATA_W-1];
            rbuf <= {rbuf[DATA_W-2:0], 1'b0};
         end
      end
   end

   // R2: a stop frees the bus and drops the output
   a_r2_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
      ev.stop |=> (state == ST_IDLE) && !ack);

   // R2: a start always re-arms address decoding at bit zero
   a_r2_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
      ev.start |=> (state == ST_ADDR) && (bitcnt == '0));

   // R9: the output moves only after a falling bit clock, start or stop
   a_r9_ack_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ack) |-> $past(ev.fall || ev.start || ev.stop));

   // R4: after a mismatched address nothing is acknowledged or written
   a_r4_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> (!ack && !we));

   // R3: the bit counter never passes the acknowledge slot
   a_r3_bit_range: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt <= ACK_SLOT);

   // R7: a read transfer never writes the register file
   a_r7_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RDATA) |-> !we);

endmodule

// File: rtl/ctl_serial_slave.sv
module ctl_serial_slave #(
   parameter int         ADDR_W      = 7,
   parameter int         DATA_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] DEV_ID      = 7'h12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_clk,
   input  logic              bus_dat,
   output logic              ack_out,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   import ssl_pkg::*;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("ctl_serial_slave: serial bytes are eight bits wide");
      end
      if ((ADDR_W < 1) || (ADDR_W > 7)) begin : g_bad_addr
         $error("ctl_serial_slave: pointer must fit in seven bits");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ctl_serial_slave: at least two synchroniser stages");
      end
   endgenerate

   ssl_evt_t          ev;
   logic [ADDR_W-1:0] ptr;
   logic              we;
   logic [DATA_W-1:0] wdata;
   logic [DATA_W-1:0] cur_byte;

   ssl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_clk (bus_clk),
      .bus_dat (bus_dat),
      .ev      (ev)
   );

   ssl_proto #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ID(DEV_ID)) u_proto (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev),
      .rdata (cur_byte),
      .ptr   (ptr),
      .we    (we),
      .wdata (wdata),
      .ack   (ack_out)
   );

   ssl_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (we),
      .waddr   (ptr),
      .wdata   (wdata),
      .raddr_a (ptr),
      .rdata_a (cur_byte),
      .raddr_b (rd_addr),
      .rdata_b (rd_data)
   );

endmodule

// File: tb/sim_ctl_serial_slave.sv
`timescale 1ns/1ps
module sim_ctl_serial_slave;

   localparam int Q = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_clk = 1'b1;
   logic       bus_dat = 1'b1;
   logic       ack_out;
   logic [6:0] rd_addr = '0;
   logic [7:0] rd_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [7:0] mdl [128];

   always #2 clk = ~clk;

   ctl_serial_slave u0 (
      .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_dat(bus_dat),
      .ack_out(ack_out), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hw(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      bus_dat = 1'b1; hw(Q);
      bus_clk = 1'b1; hw(Q);
      bus_dat = 1'b0; hw(Q);
      bus_clk = 1'b0; hw(Q);
   endtask

   task automatic bus_stop();
      bus_dat = 1'b0; hw(Q);
      bus_clk = 1'b1; hw(Q);
      bus_dat = 1'b1; hw(Q);
   endtask

   // one bit: data set while clock low, output seen before and late in the high phase
   task automatic bit_cycle(input logic b, output logic seen, output logic seen_hi);
      bus_dat = b; hw(Q);
      seen = ack_out;
      bus_clk = 1'b1; hw(Q);
      seen_hi = ack_out;
      bus_clk = 1'b0; hw(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ackbit);
      logic s, h;
      for (int i = 7; i >= 0; i--) bit_cycle(b[i], s, h);
      bit_cycle(1'b1, ackbit, h);
   endtask

   task automatic read_byte(output logic [7:0] v, output logic slot, output logic steady);
      logic s, h;
      steady = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         bit_cycle(1'b1, s, h);
         v[i] = ~s;
         if (s !== h) steady = 1'b0;
      end
      bit_cycle(1'b0, slot, h);
   endtask

   task automatic write_seq(input logic [7:0] p, input int len, input logic [7:0] base);
      logic a;
      logic [7:0] d;
      bus_start();
      send_byte(8'h24, a); check("R3 write address ack", a, 1);
      send_byte(p, a);     check("R5 pointer ack", a, 1);
      for (int k = 0; k < len; k++) begin
         d = base + 8'(k * 37);
         send_byte(d, a);  check("R5 data ack", a, 1);
         mdl[7'(p[6:0] + 7'(k))] = d;
      end
      bus_stop();
   endtask

   task automatic read_seq(input logic [7:0] p, input int len);
      logic a, slot, st;
      logic [7:0] v;
      bus_start(); send_byte(8'h24, a); send_byte(p, a); bus_stop();
      bus_start();
      send_byte(8'h25, a); check("R3 read address ack", a, 1);
      for (int k = 0; k < len; k++) begin
         read_byte(v, slot, st);
         check("R7 read data inverted", v, mdl[7'(p[6:0] + 7'(k))]);
         check("R8 released in read ack slot", slot, 0);
         check("R9 stable while clock high", st, 1);
      end
      bus_stop(); hw(Q);
      check("R8 low after stop", ack_out, 0);
   endtask

   function automatic logic [7:0] port_expect(input logic [6:0] a);
      return mdl[a];
   endfunction

   task automatic port_chk(input string req, input logic [6:0] a);
      rd_addr = a; hw(1);
      check(req, rd_data, port_expect(a));
   endtask

   initial begin
      logic a;
      logic [7:0] p;
      int len;
      for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
      void'($urandom(32'd2024));
      hw(5); rst_n = 1'b1; hw(5);

      // R1 reset state
      check("R1 ack low after reset", ack_out, 0);
      port_chk("R1 reg 00 zero", 7'h00);
      port_chk("R1 reg 7F zero", 7'h7F);

      // R5 / R10 single write
      write_seq(8'h00, 1, 8'hAA);
      port_chk("R10 port reads written reg", 7'h00);

      // R6 wrap on write
      write_seq(8'h7E, 3, 8'h11);
      port_chk("R6 write wrap 7F", 7'h7F);
      port_chk("R6 write wrap 00", 7'h00);

      // R4 wrong address then more bytes
      bus_start();
      send_byte(8'h26, a); check("R4 no ack on mismatch", a, 0);
      send_byte(8'h7E, a); check("R4 later byte ignored", a, 0);
      send_byte(8'h55, a); check("R4 later byte ignored", a, 0);
      bus_stop();
      port_chk("R4 reg 7E unchanged", 7'h7E);

      // R2 bytes after a stop are dead
      bus_start(); send_byte(8'h24, a); send_byte(8'h10, a); bus_stop();
      send_byte(8'h24, a); check("R2 no ack without start", a, 0);
      send_byte(8'h10, a); send_byte(8'h99, a); bus_stop();
      port_chk("R2 reg 10 unchanged", 7'h10);

      // R2 restart in mid transfer
      bus_start(); send_byte(8'h24, a); send_byte(8'h20, a);
      bus_dat = 1'b1; hw(Q);
      bus_start();
      send_byte(8'h24, a); check("R2 restart address ack", a, 1);
      send_byte(8'h30, a); send_byte(8'h77, a); bus_stop();
      mdl[7'h30] = 8'h77;
      port_chk("R2 restart write lands", 7'h30);
      port_chk("R2 restart no stray write", 7'h20);

      // R11 pointer bit 7 ignored
      bus_start(); send_byte(8'h24, a); send_byte(8'h85, a); send_byte(8'h3C, a); bus_stop();
      mdl[7'h05] = 8'h3C;
      port_chk("R11 pointer bit7 ignored", 7'h05);

      // R7 / R6 read with wrap
      read_seq(8'h7F, 2);
      read_seq(8'h00, 1);

      // random write then read back
      for (int it = 0; it < 12; it++) begin
         p   = 8'($urandom_range(0, 255));
         len = int'($urandom_range(1, 4));
         write_seq(p, len, 8'($urandom));
         port_chk("R10 random port", p[6:0]);
         read_seq(p, len);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog all-R actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule